// File: doc/BRIEF.md
# Status Block Writer with Host Interrupt

This block reports ring progress to a host. It tracks a transmit consumer index and a receive producer index. Whenever either one differs from the values it last reported, it writes a four-word status block into host memory through a simple word-write master port. The port holds each write until the memory accepts it with `memReady`. The word carrying the update flag is always written last. A host that sees the flag set can therefore trust the rest of the block.

After a block is complete, a coalescing policy decides whether to signal the host. The host is signalled after every Nth block, or when a tick timeout runs out while some block has not yet been signalled. The signal takes one of two forms, chosen by `msiEnable`. The first is a level interrupt line, held until the host acknowledges it. The second is a single memory write of a configured data word to a configured address. That write is issued only after the status block has been written.

Top module: `statBlockWriter`

## Requirements
- R1: A status block write starts only when `txConsIdx` or `rxProdIdx` differs from the values carried by the previous block (both taken as 0 after reset). While the indices are unchanged, no memory write is issued.
- R2: Block layout relative to `sbBase`:
  - 0x04 holds the status tag in bits [7:0], with bits [31:8] zero.
  - 0x08 holds the transmit consumer index, zero-extended.
  - 0x0C holds the receive producer index, zero-extended.
  - 0x00 holds the status word, whose update flag is bit 0 and whose other bits are zero.
- R3: The four block words are written in the order 0x04, 0x08, 0x0C, 0x00, so the word with the update flag lands last.
- R4: The first block after reset carries tag 0. Each later block carries the previous tag plus one, modulo 256.
- R5: Every write the block makes to offset 0x00 sets the update flag to 1. The hardware never writes it as 0, so a flag cleared by the host stays clear until the next block.
- R6: An interrupt, whether a rise of `irqLine` or the message write, is never issued before the status word of the block that caused it has been accepted. The message write is the next write after that status word.
- R7: In line mode, `irqLine` stays high until a cycle with `irqAck` high. After that it stays low until a new qualifying event.
- R8: With `msiEnable` high, `irqLine` never rises. Each interrupt is instead one write of `msiData` to `msiAddr`.
- R9: With threshold N = `coalThresh` (0 acts as 1), an interrupt follows the status word of every Nth block counted since the last interrupt, and the other blocks raise none.
- R10: With `tickLimit` = T nonzero, and blocks left unsignalled, an interrupt is raised on the clock edge T+1 cycles after the first unsignalled block's status word was accepted, provided the block is idle by then. With T = 0 the timeout is off.
- R11: If an index changes during a block write, a second block follows the current one and carries the new values. The first block carries the values that were present when it started.
- R12: While `memWrEn` is high and `memReady` is low, `memWrEn`, `memAddr` and `memWrData` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txConsIdx | input | IDX_W | Transmit consumer index |
| rxProdIdx | input | IDX_W | Receive producer index |
| sbBase | input | ADDR_W | Byte address of the status block |
| msiEnable | input | 1 | 1: signal by memory write; 0: signal by line |
| msiAddr | input | ADDR_W | Target address of the interrupt message write |
| msiData | input | 32 | Data word of the interrupt message write |
| coalThresh | input | CNT_W | Blocks per interrupt (0 acts as 1) |
| tickLimit | input | TICK_W | Coalescing timeout in cycles, 0 disables |
| irqAck | input | 1 | Host acknowledge, drops the interrupt line |
| memReady | input | 1 | Memory accepts the current write |
| memWrEn | output | 1 | Write request valid |
| memAddr | output | ADDR_W | Write byte address |
| memWrData | output | 32 | Write data |
| irqLine | output | 1 | Level interrupt line |

## Verification
An index change applied between clock edges is taken into a snapshot at the next edge. The tag write is requested in the cycle after that, and each following word appears after the previous one is accepted. For this reason the bench does not predict write cycles. It logs every accepted write at the falling edge and compares the log with the expected sequence once the port has been quiet for twelve cycles. The line interrupt is set by the same edge that accepts the status word, and it is cleared by the edge that sees `irqAck`. The bench reads it at the next falling edge. The timeout is checked to the exact cycle: `irqLine` is sampled low after the edge T+1 cycles after the logged status write, and high after the edge one cycle later, with `memReady` held high.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  parameter int SBW_DW = 32;

  // Byte offsets inside the status block
  parameter int OFF_STAT = 0;
  parameter int OFF_TAG  = 4;
  parameter int OFF_TX   = 8;
  parameter int OFF_RX   = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TAG, ST_TX, ST_RX, ST_STAT, ST_MSI
  } sbwState_t;

  typedef enum logic [2:0] {
    SEL_TAG, SEL_TX, SEL_RX, SEL_STAT, SEL_MSI
  } wordSel_t;

  typedef struct packed {
    logic     snapLoad;  // capture indices, block starts
    logic     blkDone;   // status word accepted
    logic     sigFire;   // raise an interrupt now
    logic     wrEn;      // write request valid
    wordSel_t sel;       // which word is on the port
  } sbwStrobe_t;

endpackage

// File: rtl/sbwCtrl.sv
module sbwCtrl
  import sbw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxDiff,
  input  logic       coalHit,
  input  logic       tickHit,
  input  logic       msiEnable,
  input  logic       memReady,
  output sbwStrobe_t strb
);

  sbwState_t state;
  sbwState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strb.snapLoad = 1'b0;
    strb.blkDone  = 1'b0;
    strb.sigFire  = 1'b0;
    strb.wrEn     = 1'b0;
    strb.sel      = SEL_TAG;
    unique case (state)
      ST_IDLE: begin
        if (tickHit) begin
          strb.sigFire = 1'b1;
          if (msiEnable) stateNext = ST_MSI;
        end else if (idxDiff) begin
          strb.snapLoad = 1'b1;
          stateNext     = ST_TAG;
        end
      end
      ST_TAG: begin
        strb.wrEn = 1'b1;
        strb.sel  = SEL_TAG;
        if (memReady) stateNext = ST_TX;
      end
      ST_TX: begin
        strb.wrEn = 1'b1;
        strb.sel  = SEL_TX;
        if (memReady) stateNext = ST_RX;
      end
      ST_RX: begin
        strb.wrEn = 1'b1;
        strb.sel  = SEL_RX;
        if (memReady) stateNext = ST_STAT;
      end
      ST_STAT: begin
        strb.wrEn = 1'b1;
        strb.sel  = SEL_STAT;
        if (memReady) begin
          strb.blkDone = 1'b1;
          stateNext    = ST_IDLE;
          if (coalHit) begin
            strb.sigFire = 1'b1;
            if (msiEnable) stateNext = ST_MSI;
          end
        end
      end
      ST_MSI: begin
        strb.wrEn = 1'b1;
        strb.sel  = SEL_MSI;
        if (memReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sbwData.sv
module sbwData
  import sbw_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbwStrobe_t        strb,
  input  logic [IDX_W-1:0]  txConsIdx,
  input  logic [IDX_W-1:0]  rxProdIdx,
  input  logic [ADDR_W-1:0] sbBase,
  input  logic [ADDR_W-1:0] msiAddr,
  input  logic [SBW_DW-1:0] msiData,
  input  logic [CNT_W-1:0]  coalThresh,
  input  logic [TICK_W-1:0] tickLimit,
  input  logic              msiEnable,
  input  logic              irqAck,
  output logic              idxDiff,
  output logic              coalHit,
  output logic              tickHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SBW_DW-1:0] memWrData,
  output logic              irqLine
);

  localparam int TAG_W = 8;

  logic [IDX_W-1:0]  snapTx, snapRx;
  logic [TAG_W-1:0]  tagReg;
  logic [CNT_W-1:0]  pendCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [CNT_W-1:0]  effThresh;
  logic [CNT_W:0]    cntPlus;

  assign idxDiff   = (txConsIdx != snapTx) || (rxProdIdx != snapRx);
  assign effThresh = (coalThresh == '0) ? CNT_W'(1) : coalThresh;
  assign cntPlus   = {1'b0, pendCnt} + (CNT_W+1)'(1);
  assign coalHit   = cntPlus >= {1'b0, effThresh};
  assign tickHit   = (tickLimit != '0) && (pendCnt != '0) && (tickCnt == tickLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapTx  <= '0;
      snapRx  <= '0;
      tagReg  <= '0;
      pendCnt <= '0;
      tickCnt <= '0;
      irqLine <= 1'b0;
    end else begin
      if (strb.snapLoad) begin
        snapTx <= txConsIdx;
        snapRx <= rxProdIdx;
      end
      if (strb.blkDone) tagReg <= tagReg + TAG_W'(1);
      if (strb.sigFire)      pendCnt <= '0;
      else if (strb.blkDone) pendCnt <= pendCnt + CNT_W'(1);
      if (pendCnt == '0)            tickCnt <= '0;
      else if (tickCnt != tickLimit) tickCnt <= tickCnt + TICK_W'(1);
      if (strb.sigFire && !msiEnable) irqLine <= 1'b1;
      else if (irqAck)                irqLine <= 1'b0;
    end
  end

  always_comb begin
    memAddr   = sbBase;
    memWrData = '0;
    unique case (strb.sel)
      SEL_TAG: begin
        memAddr   = sbBase + ADDR_W'(OFF_TAG);
        memWrData = SBW_DW'(tagReg);
      end
      SEL_TX: begin
        memAddr   = sbBase + ADDR_W'(OFF_TX);
        memWrData = SBW_DW'(snapTx);
      end
      SEL_RX: begin
        memAddr   = sbBase + ADDR_W'(OFF_RX);
        memWrData = SBW_DW'(snapRx);
      end
      SEL_STAT: begin
        memAddr   = sbBase + ADDR_W'(OFF_STAT);
        memWrData = SBW_DW'(1);
      end
      SEL_MSI: begin
        memAddr   = msiAddr;
        memWrData = msiData;
      end
      default: begin
        memAddr   = sbBase;
        memWrData = '0;
      end
    endcase
  end

endmodule

// File: rtl/statBlockWriter.sv
module statBlockWriter
  import sbw_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  txConsIdx,
  input  logic [IDX_W-1:0]  rxProdIdx,
  input  logic [ADDR_W-1:0] sbBase,
  input  logic              msiEnable,
  input  logic [ADDR_W-1:0] msiAddr,
  input  logic [31:0]       msiData,
  input  logic [CNT_W-1:0]  coalThresh,
  input  logic [TICK_W-1:0] tickLimit,
  input  logic              irqAck,
  input  logic              memReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  output logic              irqLine
);

  sbwStrobe_t strb;
  logic idxDiff, coalHit, tickHit;

  sbwCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .idxDiff   (idxDiff),
    .coalHit   (coalHit),
    .tickHit   (tickHit),
    .msiEnable (msiEnable),
    .memReady  (memReady),
    .strb      (strb)
  );

  sbwData #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .TICK_W (TICK_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .txConsIdx  (txConsIdx),
    .rxProdIdx  (rxProdIdx),
    .sbBase     (sbBase),
    .msiAddr    (msiAddr),
    .msiData    (msiData),
    .coalThresh (coalThresh),
    .tickLimit  (tickLimit),
    .msiEnable  (msiEnable),
    .irqAck     (irqAck),
    .idxDiff    (idxDiff),
    .coalHit    (coalHit),
    .tickHit    (tickHit),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .irqLine    (irqLine)
  );

  assign memWrEn = strb.wrEn;

endmodule

// File: rtl/sbwChecker.sv
module sbwChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWrEn,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWrData,
  input logic              irqLine,
  input logic              irqAck,
  input logic              msiEnable,
  input logic [ADDR_W-1:0] msiAddr,
  input logic [ADDR_W-1:0] sbBase
);

  // Set when the most recently accepted write was the status word
  logic lastWasStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastWasStatus <= 1'b0;
    else if (memWrEn && memReady) lastWasStatus <= (memAddr == sbBase);
  end

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memReady) |=> (memWrEn && $stable(memAddr) && $stable(memWrData)));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memAddr == sbBase) |-> (memWrData == 32'h1));

  p_tag_upper_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memAddr == sbBase + ADDR_W'(4)) |-> (memWrData[31:8] == 24'h0));

  p_line_after_stat_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLine) |-> lastWasStatus);

  p_msg_after_stat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (msiEnable && memWrEn && memReady && memAddr == msiAddr) |-> lastWasStatus);

  p_no_line_msg_r8: assert property (@(posedge clk) disable iff (!rstN)
    msiEnable |-> !$rose(irqLine));

  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqLine && !irqAck) |=> irqLine);

endmodule

bind statBlockWriter sbwChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memWrEn   (memWrEn),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .irqLine   (irqLine),
  .irqAck    (irqAck),
  .msiEnable (msiEnable),
  .msiAddr   (msiAddr),
  .sbBase    (sbBase)
);

// File: tb/statBlockWriter_test.sv
module statBlockWriter_test;

  localparam int IDX_W = 16;
  localparam int ADDR_W = 16;
  localparam int CNT_W = 4;
  localparam int TICK_W = 8;
  localparam int LOGN = 1024;
  localparam logic [15:0] BASE = 16'h0040;
  localparam logic [15:0] MADR = 16'h0100;
  localparam logic [31:0] MDAT = 32'h5A5A_0F0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IDX_W-1:0] txConsIdx = '0, rxProdIdx = '0;
  logic [ADDR_W-1:0] sbBase = BASE, msiAddr = MADR;
  logic msiEnable = 1'b0;
  logic [31:0] msiData = MDAT;
  logic [CNT_W-1:0] coalThresh = 4'd1;
  logic [TICK_W-1:0] tickLimit = '0;
  logic irqAck = 1'b0;
  logic memReady = 1'b1;
  logic memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWrData;
  logic irqLine;

  statBlockWriter #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TICK_W(TICK_W)) uut (
    .clk(clk), .rstN(rstN), .txConsIdx(txConsIdx), .rxProdIdx(rxProdIdx),
    .sbBase(sbBase), .msiEnable(msiEnable), .msiAddr(msiAddr), .msiData(msiData),
    .coalThresh(coalThresh), .tickLimit(tickLimit), .irqAck(irqAck),
    .memReady(memReady), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .irqLine(irqLine)
  );

  always #2 clk = ~clk;

  int nVec = 0;
  int nFail = 0;
  int logN = 0;
  logic [15:0] logAddr [LOGN];
  logic [31:0] logData [LOGN];
  logic        logIrq  [LOGN];
  logic [31:0] mem [64];
  logic stallOn = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  int expTag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory acceptance, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      memReady = stallOn ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  // Write monitor and host memory model, sampled at the falling edge
  initial begin
    logic prevStall;
    logic [15:0] prevAddr;
    logic [31:0] prevData;
    prevStall = 1'b0;
    prevAddr = '0;
    prevData = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (prevStall) begin
          chk("R12 hold en", {31'b0, memWrEn}, 32'h1);
          chk("R12 hold addr", {16'b0, memAddr}, {16'b0, prevAddr});
          chk("R12 hold data", memWrData, prevData);
        end
        prevStall = memWrEn && !memReady;
        prevAddr = memAddr;
        prevData = memWrData;
        if (memWrEn && memReady) begin
          mem[memAddr[7:2]] = memWrData;
          if (logN < LOGN) begin
            logAddr[logN] = memAddr;
            logData[logN] = memWrData;
            logIrq[logN] = irqLine;
          end
          logN++;
        end
      end else begin
        prevStall = 1'b0;
      end
    end
  end

  task automatic waitIdle();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (memWrEn) q = 0;
      else q++;
    end
  endtask

  task automatic ack();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic checkBlock(input int s, input logic [15:0] tx, input logic [15:0] rx);
    chk("R3 tag word addr", {16'b0, logAddr[s]}, {16'b0, BASE + 16'h4});
    chk("R4 tag value", logData[s], expTag & 255);
    chk("R3 tx word addr", {16'b0, logAddr[s+1]}, {16'b0, BASE + 16'h8});
    chk("R2 tx value", logData[s+1], {16'b0, tx});
    chk("R3 rx word addr", {16'b0, logAddr[s+2]}, {16'b0, BASE + 16'hC});
    chk("R2 rx value", logData[s+2], {16'b0, rx});
    chk("R3 status word last", {16'b0, logAddr[s+3]}, {16'b0, BASE});
    chk("R2 status flag", logData[s+3], 32'h1);
    expTag++;
  endtask

  task automatic doBlock(input logic [15:0] tx, input logic [15:0] rx);
    @(negedge clk);
    logN = 0;
    txConsIdx = tx;
    rxProdIdx = rx;
    waitIdle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    int u;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk("R7 reset irqLine", {31'b0, irqLine}, 32'h0);
    chk("R1 reset memWrEn", {31'b0, memWrEn}, 32'h0);
    rstN = 1'b1;
    logN = 0;
    repeat (20) @(negedge clk);
    chk("R1 no write with unchanged indices", logN, 0);

    // Layout, order, first tag, line interrupt, acknowledge
    doBlock(16'd5, 16'd9);
    chk("R3 write count", logN, 4);
    checkBlock(0, 16'd5, 16'd9);
    chk("R6 line low during block", {31'b0, logIrq[0] | logIrq[1] | logIrq[2] | logIrq[3]}, 32'h0);
    chk("R9 line after block N=1", {31'b0, irqLine}, 32'h1);
    mem[BASE[7:2]] = 32'h0;
    ack();
    chk("R7 ack drops line", {31'b0, irqLine}, 32'h0);
    logN = 0;
    repeat (30) @(negedge clk);
    chk("R7 no reassert", {31'b0, irqLine}, 32'h0);
    chk("R5 host clear kept", mem[BASE[7:2]], 32'h0);
    chk("R1 no spurious write", logN, 0);

    // Coalescing sweep over thresholds, memory stalls on
    stallOn = 1'b1;
    u = 100;
    for (int n = 0; n <= 4; n++) begin
      int effN;
      coalThresh = CNT_W'(n);
      effN = (n == 0) ? 1 : n;
      for (int k = 1; k <= 2 * effN; k++) begin
        u++;
        doBlock(16'(u), 16'(u * 3 + 1));
        chk("R3 write count", logN, 4);
        checkBlock(0, 16'(u), 16'(u * 3 + 1));
        chk("R5 flag set again", mem[BASE[7:2]], 32'h1);
        mem[BASE[7:2]] = 32'h0;
        chk("R9 coalesced line", {31'b0, irqLine}, {31'b0, (k % effN) == 0});
        if (irqLine) ack();
      end
    end

    // Tag wrap over 260 blocks
    stallOn = 1'b0;
    coalThresh = 4'd1;
    for (int k = 0; k < 260; k++) begin
      u++;
      doBlock(16'(u), 16'(u ^ 16'h00FF));
      chk("R4 tag sequence", logData[0], expTag & 255);
      expTag++;
      ack();
    end

    // Message-signalled mode, N=2
    msiEnable = 1'b1;
    coalThresh = 4'd2;
    u++;
    doBlock(16'(u), 16'h1111);
    chk("R9 no message on first", logN, 4);
    checkBlock(0, 16'(u), 16'h1111);
    u++;
    doBlock(16'(u), 16'h2222);
    chk("R8 message write present", logN, 5);
    checkBlock(0, 16'(u), 16'h2222);
    chk("R6 message follows status", {16'b0, logAddr[4]}, {16'b0, MADR});
    chk("R8 message data", logData[4], MDAT);
    chk("R8 line stays low", {31'b0, irqLine}, 32'h0);

    // Timeout in line mode, exact cycle
    msiEnable = 1'b0;
    coalThresh = 4'd4;
    tickLimit = 8'd10;
    @(negedge clk);
    logN = 0;
    u++;
    txConsIdx = 16'(u);
    while (logN < 4) @(negedge clk);
    checkBlock(0, 16'(u), 16'h2222);
    repeat (11) @(negedge clk);
    chk("R10 not yet at T", {31'b0, irqLine}, 32'h0);
    @(negedge clk);
    chk("R10 raised at T+1", {31'b0, irqLine}, 32'h1);
    ack();
    repeat (30) @(negedge clk);
    chk("R7 timeout not repeated", {31'b0, irqLine}, 32'h0);

    // Timeout in message mode
    msiEnable = 1'b1;
    u++;
    doBlock(16'(u), 16'h2222);
    repeat (20) @(negedge clk);
    chk("R10 message by timeout", logN, 5);
    checkBlock(0, 16'(u), 16'h2222);
    chk("R8 timeout message addr", {16'b0, logAddr[4]}, {16'b0, MADR});
    chk("R8 timeout line low", {31'b0, irqLine}, 32'h0);

    // Index change while a block is in flight
    msiEnable = 1'b0;
    tickLimit = '0;
    coalThresh = 4'd1;
    stallOn = 1'b1;
    @(negedge clk);
    logN = 0;
    u++;
    txConsIdx = 16'(u);
    while (logN < 1) @(negedge clk);
    rxProdIdx = 16'h3333;
    waitIdle();
    chk("R11 two blocks", logN, 8);
    checkBlock(0, 16'(u), 16'h2222);
    checkBlock(4, 16'(u), 16'h3333);
    chk("R9 line after pending", {31'b0, irqLine}, 32'h1);
    ack();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule